// File: doc/BRIEF.md
# Four-Channel Single-Transfer DMA Sequencer

This block sequences direct-memory-access transfers for several requesting channels that share one bus with a CPU. Each channel has a request line, a transfer count and an enable bit. When any enabled channel has a request waiting, the sequencer asks for the bus. Once it holds the bus, it issues exactly one transfer strobe, tagged with the winning channel's number. It then gives the bus back as soon as the bus side reports that transfer complete. Address generation and data movement belong to the logic that consumes the strobe.

Because the bus is returned after every transfer, the channel choice is made again at every grant. A long run on one channel is therefore interleaved with CPU cycles, and a higher-priority channel can step in between two of its transfers. The count register holds the number of transfers minus one. When a channel's last transfer finishes, the block gives that channel a one-cycle completion interrupt and clears its enable.

Software programs a channel through a simple write port, and only while that channel has no transfer in flight. Channel 0 outranks channel 1, and so on down to the highest-numbered channel.

Top module: `dma_seq_top`

## Requirements
- R1: After every transfer, `bus_req` is low in the cycle after the cycle in which `bus_done` is sampled high, even if requests are still pending.
- R2: A rising edge of `bus_req` happens only when `bus_gnt` was low in the previous cycle, and `bus_req` was also low in that cycle.
- R3: A channel whose count register was loaded with N performs exactly N+1 transfers, given enough requests. Count value 0 means one transfer, 1 means two and 3 means four.
- R4: At every grant, the transfer goes to the lowest-numbered channel with a pending request (channel 0 highest priority).
- R5: A request pulse on an enabled channel is held as pending until that channel's transfer is strobed. Several pulses on the same channel before it is served merge into a single transfer.
- R6: A channel's bit of `tc_irq` is high for exactly one cycle, namely the cycle after `bus_done` of that channel's final transfer. At most one bit of `tc_irq` is high at a time.
- R7: A channel's bit of `chan_en` clears together with its completion pulse. A request on a channel whose enable is 0 produces no transfer strobe.
- R8: A configuration write addressed to the channel whose transfer is in flight (between its strobe and its `bus_done`) changes neither its enable nor its count.
- R9: During and right after reset, `bus_req`, `xfer_strobe`, `tc_irq` and `chan_en` are all 0.
- R10: `xfer_strobe` is high for exactly one cycle: the cycle after the grant is sampled. `xfer_chan` holds the winning channel's binary index while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | NCH | Per-channel transfer request, one bit per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | CHW | Channel addressed by the write (binary index) |
| cfg_count | input | CW | Transfers minus one, loaded on write |
| cfg_enable | input | 1 | Enable value loaded on write |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted to the sequencer |
| bus_done | input | 1 | Current transfer complete on the bus |
| xfer_strobe | output | 1 | One-cycle transfer start |
| xfer_chan | output | CHW | Channel served by the current strobe |
| tc_irq | output | NCH | Per-channel one-cycle completion interrupt |
| chan_en | output | NCH | Per-channel enable state |

## Verification
The assertions assume a well-behaved bus partner. It raises `bus_gnt` only while `bus_req` is high and keeps it high until `bus_req` falls. It pulses `bus_done` only after the strobe of the current transfer. It never grants while there is nothing pending. The bench's bus model follows this contract exactly: it waits a random number of cycles before granting and before signalling done, and it drops the grant only after it sees the request fall. Configuration writes come only from the bench's own tasks, at points where the target channel's state is known.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_XFER,
    ST_WAIT,
    ST_REL
  } seq_state_e;

  // Index of the lowest set bit (highest priority); 0 when none is set.
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // A count of zero means the coming transfer is the channel's last one.
  function automatic logic count_is_final(input logic [31:0] c);
    return (c == 32'd0);
  endfunction

  // Remaining count after one transfer.
  function automatic logic [31:0] count_after(input logic [31:0] c);
    return (c == 32'd0) ? 32'd0 : c - 32'd1;
  endfunction

endpackage

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] pend,
  output logic           any,
  output logic [CHW-1:0] win
);
  import dma_seq_pkg::*;

  logic [31:0] pend_wide;

  always_comb begin
    pend_wide = '0;
    pend_wide[NCH-1:0] = pend;
  end

  assign any = |pend;
  assign win = CHW'(lowest_set(pend_wide));

endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [CW-1:0] wr_cnt,
  input  logic          wr_en,
  input  logic          take,
  input  logic          fin,
  output logic          pend,
  output logic          en,
  output logic          tc,
  output logic          final_cnt
);
  import dma_seq_pkg::*;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en    <= 1'b0;
      pend  <= 1'b0;
      tc    <= 1'b0;
    end else begin
      tc <= fin;
      if (wr) begin
        cnt_q <= wr_cnt;
        en    <= wr_en;
      end else begin
        if (fin)  en    <= 1'b0;
        if (take) cnt_q <= CW'(count_after(32'(cnt_q)));
      end
      if (fin || (wr && !wr_en)) pend <= 1'b0;
      else                       pend <= (pend & ~take) | (req & en);
    end
  end

  assign final_cnt = count_is_final(32'(cnt_q));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm #(
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_pend,
  input  logic [CHW-1:0] win,
  input  logic           bus_gnt,
  input  logic           bus_done,
  input  logic           last_in,
  output logic           bus_req,
  output logic           grant_take,
  output logic           xfer_fire,
  output logic           done_take,
  output logic           final_done,
  output logic           in_flight,
  output logic [CHW-1:0] cur
);
  import dma_seq_pkg::*;

  seq_state_e state_q, state_nx;
  logic       last_q;

  assign grant_take = (state_q == ST_ARB) && bus_gnt && any_pend;
  assign xfer_fire  = (state_q == ST_XFER);
  assign done_take  = (state_q == ST_WAIT) && bus_done;
  assign final_done = done_take && last_q;
  assign in_flight  = (state_q == ST_XFER) || (state_q == ST_WAIT);
  assign bus_req    = (state_q == ST_ARB) || in_flight;

  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE: if (any_pend && !bus_gnt) state_nx = ST_ARB;
      ST_ARB:  if (bus_gnt) state_nx = any_pend ? ST_XFER : ST_REL;
      ST_XFER: state_nx = ST_WAIT;
      ST_WAIT: if (bus_done) state_nx = ST_REL;
      ST_REL:  if (!bus_gnt) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
      cur     <= '0;
    end else begin
      state_q <= state_nx;
      if (grant_take) cur    <= win;
      if (xfer_fire)  last_q <= last_in;
    end
  end

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top #(
  parameter int NCH = 4,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_sel,
  input  logic [CW-1:0]  cfg_count,
  input  logic           cfg_enable,
  output logic           bus_req,
  input  logic           bus_gnt,
  input  logic           bus_done,
  output logic           xfer_strobe,
  output logic [CHW-1:0] xfer_chan,
  output logic [NCH-1:0] tc_irq,
  output logic [NCH-1:0] chan_en
);

  // Named internal events, also watched by the checker.
  logic [NCH-1:0] pend_vec;
  logic [NCH-1:0] fin_cnt_vec;
  logic [NCH-1:0] busy_vec;
  logic           any_pend;
  logic [CHW-1:0] win_idx;
  logic [CHW-1:0] cur_chan;
  logic           grant_take;
  logic           xfer_fire;
  logic           done_take;
  logic           final_done;
  logic           in_flight;
  logic           last_in;

  dma_seq_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .pend (pend_vec),
    .any  (any_pend),
    .win  (win_idx)
  );

  assign last_in = fin_cnt_vec[cur_chan];

  dma_seq_fsm #(.CHW(CHW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_pend   (any_pend),
    .win        (win_idx),
    .bus_gnt    (bus_gnt),
    .bus_done   (bus_done),
    .last_in    (last_in),
    .bus_req    (bus_req),
    .grant_take (grant_take),
    .xfer_fire  (xfer_fire),
    .done_take  (done_take),
    .final_done (final_done),
    .in_flight  (in_flight),
    .cur        (cur_chan)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic sel_me, wr_ok;
    assign sel_me      = (cur_chan == CHW'(i));
    assign busy_vec[i] = in_flight && sel_me;
    assign wr_ok       = cfg_we && (cfg_sel == CHW'(i)) && !busy_vec[i];

    dma_seq_chan #(.CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (chan_req[i]),
      .wr        (wr_ok),
      .wr_cnt    (cfg_count),
      .wr_en     (cfg_enable),
      .take      (xfer_fire && sel_me),
      .fin       (final_done && sel_me),
      .pend      (pend_vec[i]),
      .en        (chan_en[i]),
      .tc        (tc_irq[i]),
      .final_cnt (fin_cnt_vec[i])
    );
  end

  assign xfer_strobe = xfer_fire;
  assign xfer_chan   = cur_chan;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           xfer_strobe,
  input logic [CHW-1:0] xfer_chan,
  input logic [NCH-1:0] tc_irq,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] pend_vec,
  input logic [NCH-1:0] busy_vec,
  input logic [CHW-1:0] win_idx,
  input logic [CHW-1:0] cur_chan,
  input logic           grant_take,
  input logic           done_take,
  input logic           final_done
);

  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_take |=> !bus_req);

  assert_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(!bus_gnt));

  assert_tc_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_irq));

  assert_tc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_irq != '0) |=> (tc_irq == '0));

  assert_tc_after_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
    final_done |=> $countones(tc_irq) == 1);

  assert_strobe_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_strobe |-> chan_en[xfer_chan]);

  assert_strobe_after_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_take |=> xfer_strobe && (xfer_chan == $past(win_idx)));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_strobe |=> !xfer_strobe);

  assert_strobe_holds_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_strobe |-> bus_req);

  for (genvar i = 0; i < NCH; i++) begin : g_per_chan
    assert_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_take && pend_vec[i]) |-> (win_idx <= CHW'(i)));

    assert_winner_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_take && (win_idx == CHW'(i))) |-> pend_vec[i]);

    assert_en_off_at_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tc_irq[i] |-> !chan_en[i]);

    assert_busy_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_vec[i] && !final_done) |=> $stable(chan_en[i]));
  end

endmodule

bind dma_seq_top dma_seq_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_gnt     (bus_gnt),
  .xfer_strobe (xfer_strobe),
  .xfer_chan   (xfer_chan),
  .tc_irq      (tc_irq),
  .chan_en     (chan_en),
  .pend_vec    (pend_vec),
  .busy_vec    (busy_vec),
  .win_idx     (win_idx),
  .cur_chan    (cur_chan),
  .grant_take  (grant_take),
  .done_take   (done_take),
  .final_done  (final_done)
);

// File: tb/test_dma_seq_top.sv
module test_dma_seq_top;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int CHW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] chan_req = '0;
  logic           cfg_we = 1'b0;
  logic [CHW-1:0] cfg_sel = '0;
  logic [CW-1:0]  cfg_count = '0;
  logic           cfg_enable = 1'b0;
  logic           bus_req;
  logic           bus_gnt = 1'b0;
  logic           bus_done = 1'b0;
  logic           xfer_strobe;
  logic [CHW-1:0] xfer_chan;
  logic [NCH-1:0] tc_irq;
  logic [NCH-1:0] chan_en;

  always #10 clk = ~clk;

  dma_seq_top #(.NCH(NCH), .CW(CW)) i_dma_seq_top (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_count(cfg_count),
    .cfg_enable(cfg_enable), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_done(bus_done), .xfer_strobe(xfer_strobe), .xfer_chan(xfer_chan),
    .tc_irq(tc_irq), .chan_en(chan_en)
  );

  int total = 0;
  int bad = 0;
  int served [NCH];
  int ntc [NCH];
  int cnt_model [NCH];
  int seq [64];
  int seqn = 0;
  bit hold = 1'b0;
  int done_extra = 0;
  bit prev_req = 1'b0;
  bit prev_gnt = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Bench rule: expected completion mask of a transfer
  function automatic int tc_expect(input int ch, input bit last);
    return last ? (1 << ch) : 0;
  endfunction

  // Bench rule: transfers implied by a count value
  function automatic int transfers_for(input int cnt);
    return cnt + 1;
  endfunction

  // Bus partner model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bus_req && !bus_gnt) begin
        int d;
        int ch;
        bit last;
        d = $urandom_range(0, 2);
        repeat (d) @(negedge clk);
        while (hold) @(negedge clk);
        bus_gnt = 1'b1;
        @(negedge clk);
        check(xfer_strobe == 1'b1, "R10", "strobe one cycle after grant",
              int'(xfer_strobe), 1);
        ch = int'(xfer_chan);
        served[ch]++;
        if (seqn < 64) begin
          seq[seqn] = ch;
          seqn++;
        end
        last = (served[ch] == transfers_for(cnt_model[ch]));
        @(negedge clk);
        check(xfer_strobe == 1'b0, "R10", "strobe single cycle",
              int'(xfer_strobe), 0);
        d = $urandom_range(0, 3) + done_extra;
        repeat (d) @(negedge clk);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        check(bus_req == 1'b0, "R1", "bus released after done", int'(bus_req), 0);
        check(int'(tc_irq) == tc_expect(ch, last), "R6", "tc after done",
              int'(tc_irq), tc_expect(ch, last));
        @(negedge clk);
        check(tc_irq == '0, "R6", "tc one cycle", int'(tc_irq), 0);
        bus_gnt = 1'b0;
      end
    end
  end

  // Monitor: request gap rule and completion counting
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && !prev_req)
        check(!prev_gnt, "R2", "grant low before request", int'(prev_gnt), 0);
      for (int i = 0; i < NCH; i++)
        if (tc_irq[i]) ntc[i]++;
    end
    prev_req = bus_req;
    prev_gnt = bus_gnt;
  end

  task automatic cfg(input int ch, input int cnt, input bit en, input bit model);
    @(negedge clk);
    cfg_we     = 1'b1;
    cfg_sel    = ch[CHW-1:0];
    cfg_count  = cnt[CW-1:0];
    cfg_enable = en;
    @(negedge clk);
    cfg_we = 1'b0;
    if (model) cnt_model[ch] = cnt;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk);
    chan_req[ch] = 1'b1;
    @(negedge clk);
    chan_req[ch] = 1'b0;
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NCH; i++) begin
      served[i] = 0;
      ntc[i] = 0;
    end
    seqn = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-requirements act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1DA5));
    for (int i = 0; i < NCH; i++) cnt_model[i] = 0;
    clear_counts();
    repeat (5) @(negedge clk);
    check(bus_req == 1'b0 && xfer_strobe == 1'b0, "R9", "reset bus idle",
          int'(bus_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_req == 1'b0, "R9", "bus_req after reset", int'(bus_req), 0);
    check(tc_irq == '0, "R9", "tc after reset", int'(tc_irq), 0);
    check(chan_en == '0, "R9", "enables after reset", int'(chan_en), 0);
    check(xfer_strobe == 1'b0, "R9", "strobe after reset", int'(xfer_strobe), 0);

    // Disabled channel ignores requests (R7)
    pulse(1);
    repeat (15) @(negedge clk);
    check(served[1] == 0, "R7", "no transfer while disabled", served[1], 0);

    // Count 3 means four transfers (R3, R6, R7)
    cfg(0, 3, 1'b1, 1'b1);
    for (int k = 0; k < 6; k++) begin
      pulse(0);
      repeat (25) @(negedge clk);
    end
    check(served[0] == 4, "R3", "count 3 gives four transfers", served[0], 4);
    check(ntc[0] == 1, "R6", "one completion pulse", ntc[0], 1);
    check(chan_en[0] == 1'b0, "R7", "enable cleared at end", int'(chan_en[0]), 0);
    pulse(0);
    repeat (20) @(negedge clk);
    check(served[0] == 4, "R7", "request after end ignored", served[0], 4);

    // Priority and latching while bus is withheld (R4, R5)
    clear_counts();
    for (int i = 0; i < NCH; i++) cfg(i, 7, 1'b1, 1'b1);
    hold = 1'b1;
    pulse(3);
    pulse(3);
    pulse(2);
    pulse(1);
    repeat (4) @(negedge clk);
    hold = 1'b0;
    while (seqn == 0) @(negedge clk);
    pulse(0);
    repeat (80) @(negedge clk);
    check(seqn == 4, "R5", "merged pulses give one transfer each", seqn, 4);
    check(seq[0] == 1, "R4", "first winner", seq[0], 1);
    check(seq[1] == 0, "R4", "late high priority preempts", seq[1], 0);
    check(seq[2] == 2, "R4", "third winner", seq[2], 2);
    check(seq[3] == 3, "R4", "fourth winner", seq[3], 3);
    check(served[3] == 1, "R5", "double pulse on ch3 merged", served[3], 1);

    // Writes to the in-flight channel are ignored (R8)
    for (int i = 0; i < NCH; i++) cfg(i, 0, 1'b0, 1'b1);
    clear_counts();
    cfg(2, 1, 1'b1, 1'b1);
    done_extra = 5;
    pulse(2);
    while (served[2] == 0) @(negedge clk);
    cfg(2, 5, 1'b0, 1'b0);
    check(chan_en[2] == 1'b1, "R8", "enable kept during flight", int'(chan_en[2]), 1);
    done_extra = 0;
    repeat (30) @(negedge clk);
    pulse(2);
    repeat (30) @(negedge clk);
    pulse(2);
    repeat (30) @(negedge clk);
    check(served[2] == 2, "R8", "count kept during flight", served[2], 2);
    check(ntc[2] == 1, "R6", "ch2 completion", ntc[2], 1);

    // Random rounds
    for (int r = 0; r < 40; r++) begin
      int lim;
      clear_counts();
      for (int i = 0; i < NCH; i++) cfg(i, $urandom_range(0, 5), 1'b1, 1'b1);
      lim = 0;
      while (chan_en != '0 && lim < 1000) begin
        @(negedge clk);
        for (int i = 0; i < NCH; i++) chan_req[i] = ($urandom_range(0, 3) == 0);
        lim++;
      end
      chan_req = '0;
      repeat (30) @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        check(served[i] == transfers_for(cnt_model[i]), "R3", "random transfer total",
              served[i], transfers_for(cnt_model[i]));
        check(ntc[i] == 1, "R6", "random completion count", ntc[i], 1);
      end
      check(chan_en == '0, "R7", "random enables cleared", int'(chan_en), 0);
    end

    summary();
    $finish;
  end

endmodule